// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into an IEEE 754 binary value. The operand can be read as a signed or unsigned integer of 32 or 64 bits. The result is either a double, or a single that has been rounded to single precision and then widened into the 64-bit double register layout.

Alongside the value, the block returns an inexact flag, a five-bit result class code and a strobe. The strobe tells the surrounding status logic whether this conversion is allowed to update status at all. One case is always exact: a 32-bit source with a double result. For that case the strobe stays low and no flag is raised.

The datapath has three parts: a sign/magnitude stage, a leading-zero count with a left normalising shift, and a rounder. The rounder uses the round bit and a sticky OR of the discarded bits, under a two-bit dynamic rounding mode. One register stage sits at the output.

Top module: `i2f_convert`

## Requirements
- R1: After reset the outputs are all zero: `out_valid`, `result`, `inexact`, `fp_class` and `flag_update`.
- R2: `int_kind` selects how the operand is read: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. For kinds 0 and 1, bits 63:32 of the operand are ignored. An unsigned kind never gives a negative result.
- R3: Every conversion presented with `in_valid` high appears on the outputs, with `out_valid` high, on the next rising clock edge. A cycle with `in_valid` low gives `out_valid` low on the next edge.
- R4: `prec_mode` bit 1 set requests single precision. The value is rounded to a 24-bit significand and stored in double layout, so result bits 28:0 are zero and the exponent is rebiased to 1023. With bit 1 clear, the value is rounded to a 53-bit significand.
- R5: When `int_kind` bit 1 and `prec_mode` bit 1 are both clear (a 32-bit source with a double result), `flag_update` and `inexact` stay low.
- R6: In every other combination, `flag_update` is high with the result. `inexact` is high exactly when the rounding discarded nonzero bits.
- R7: `rnd_mode` selects the rounding: 0 nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R8: `fp_class` is 5'h12 for +0, 5'h04 for a positive normal value and 5'h08 for a negative normal value. It is computed from the rounded value.
- R9: A zero operand (the selected width being zero) gives an all-zero result, class 5'h12 and no inexact flag.
- R10: The most negative signed value converts exactly to minus a power of two. This gives 64'hC1E0000000000000 for the 32-bit kind and 64'hC3E0000000000000 for the 64-bit kind.
- R11: `prec_mode` bit 0 has no effect on any output.
- R12: A rounding carry out of the significand raises the exponent by one. For example, unsigned 64-bit all-ones rounded to nearest gives 64'h43F0000000000000 with `inexact` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Integer source value |
| int_kind | input | 2 | Integer interpretation (R2 encoding) |
| prec_mode | input | 2 | Bit 1: single result; bit 0: no effect |
| rnd_mode | input | 2 | Dynamic rounding mode (R7 encoding) |
| out_valid | output | 1 | Result registers hold a new conversion |
| result | output | 64 | Floating-point result in double layout |
| inexact | output | 1 | Rounding lost precision (qualified by `flag_update`) |
| fp_class | output | 5 | Class code of the rounded result |
| flag_update | output | 1 | Status may be updated by this conversion |

## Verification
All results are registered once, so every output is due exactly one clock after the cycle in which its operand was presented. The bench drives inputs on the falling edge. On each later falling edge it compares all five outputs against the expectation saved from the previous drive. Back-to-back operands therefore check the single-cycle latency on every cycle, without gaps between them. The reference model works from integer arithmetic. It finds the top bit, discards the excess bits, compares the remainder against one half and then packs the fields. It shares no structure with the shift-and-sticky datapath.

// File: rtl/i2f_pkg.sv
// Shared encodings and format constants for the integer to float converter.
// Assumes IEEE 754 binary64 as the register layout for both precisions.
package i2f_pkg;
    localparam int OP_W     = 64;
    localparam int DBL_FRAC = 52;
    localparam int SGL_FRAC = 23;
    localparam int EXP_W    = 11;
    localparam int EXP_BIAS = 1023;
    localparam int CLS_W    = 5;
    localparam int LZ_W     = $clog2(OP_W + 1);

    typedef enum logic [1:0] {
        KIND_S32 = 2'd0,
        KIND_U32 = 2'd1,
        KIND_S64 = 2'd2,
        KIND_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_mode_e;

    localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'h12;
    localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'h04;
    localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'h08;
endpackage

// File: rtl/i2f_operand_prep.sv
// Splits the operand into a sign and an unsigned magnitude according to the
// integer kind. Assumes 32-bit kinds use only the low half of the operand.
module i2f_operand_prep
    import i2f_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W-1:0] operand,
    input  logic [1:0]   kind,
    output logic         sign,
    output logic [W-1:0] mag
);
    localparam int HW = W / 2;

    logic [W-1:0] narrow;
    logic         is_signed;
    logic         wide;

    // Select the active width, zero-extend the narrow case, derive the sign.
    always_comb begin
        wide      = kind[1];
        is_signed = ~kind[0];
        narrow    = {{HW{1'b0}}, operand[HW-1:0]};
        if (wide) begin
            sign = is_signed & operand[W-1];
        end else begin
            sign = is_signed & operand[HW-1];
        end
    end

    // Two's complement negation of the selected field gives the magnitude.
    always_comb begin
        if (wide) begin
            mag = sign ? (~operand + W'(1)) : operand;
        end else begin
            mag = sign ? ((~narrow + W'(1)) & {{HW{1'b0}}, {HW{1'b1}}}) : narrow;
        end
    end
endmodule

// File: rtl/i2f_lzc.sv
// Leading-zero counter. Returns W when the vector is all zero.
// Assumes W fits in CW bits with room for the value W itself.
module i2f_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Scan upward; the highest set bit is the last one to write the count.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/i2f_rounder.sv
// Rounds a left-normalised magnitude (leading one at the top bit) to FRAC_W
// fraction bits under the dynamic mode. Reports a carry out of the fraction
// and whether any discarded bit was set. Assumes IN_W >= FRAC_W + 3.
module i2f_rounder
    import i2f_pkg::*;
#(
    parameter int IN_W   = OP_W,
    parameter int FRAC_W = DBL_FRAC
) (
    input  logic [IN_W-1:0]   norm,
    input  logic              sign,
    input  logic [1:0]        rnd_mode,
    output logic [FRAC_W-1:0] frac_out,
    output logic              carry,
    output logic              lost
);
    localparam int CUT = IN_W - 1 - FRAC_W;

    logic [FRAC_W-1:0] frac_t;
    logic              keep_lsb;
    logic              round_bit;
    logic              sticky;
    logic              bump;
    logic [FRAC_W:0]   sum;

    // Slice kept fraction, round bit and the sticky OR of the remaining bits.
    always_comb begin
        frac_t    = norm[IN_W-2 -: FRAC_W];
        keep_lsb  = norm[CUT];
        round_bit = norm[CUT-1];
        sticky    = |norm[CUT-2:0];
        lost      = round_bit | sticky;
    end

    // Decide whether to increment the kept fraction.
    always_comb begin
        unique case (rnd_mode_e'(rnd_mode))
            RND_NEAR: bump = round_bit & (sticky | keep_lsb);
            RND_ZERO: bump = 1'b0;
            RND_UP:   bump = ~sign & lost;
            RND_DOWN: bump = sign & lost;
            default:  bump = 1'b0;
        endcase
    end

    // Apply the increment; a carry means the significand reached 2.0.
    always_comb begin
        sum      = {1'b0, frac_t} + (FRAC_W + 1)'(bump);
        carry    = sum[FRAC_W];
        frac_out = sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/i2f_convert.sv
// Integer to floating-point converter with one output register stage.
// Assumes a single-precision result is delivered widened into double layout
// and that a 32-bit source converted to double never updates status.
module i2f_convert
    import i2f_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  operand,
    input  logic [1:0]       int_kind,
    input  logic [1:0]       prec_mode,
    input  logic [1:0]       rnd_mode,
    output logic             out_valid,
    output logic [OP_W-1:0]  result,
    output logic             inexact,
    output logic [CLS_W-1:0] fp_class,
    output logic             flag_update
);
    localparam int PAD_W = DBL_FRAC - SGL_FRAC;

    logic              sign;
    logic [OP_W-1:0]   mag;
    logic [LZ_W-1:0]   lz;
    logic [OP_W-1:0]   norm;
    logic [DBL_FRAC-1:0] frac_d;
    logic [SGL_FRAC-1:0] frac_s;
    logic              carry_d, carry_s, lost_d, lost_s;
    logic              single;
    logic              is_zero;
    logic              exact_path;
    logic [DBL_FRAC-1:0] frac_sel;
    logic              carry_sel, lost_sel;
    logic [EXP_W-1:0]  exp_field;
    logic [OP_W-1:0]   value_c;
    logic [CLS_W-1:0]  class_c;

    i2f_operand_prep #(.W(OP_W)) u_prep (
        .operand (operand),
        .kind    (int_kind),
        .sign    (sign),
        .mag     (mag)
    );

    i2f_lzc #(.W(OP_W), .CW(LZ_W)) u_lzc (
        .vec   (mag),
        .count (lz)
    );

    // Left-normalise so the leading one sits at the top bit.
    always_comb begin
        norm = mag << lz;
    end

    i2f_rounder #(.IN_W(OP_W), .FRAC_W(DBL_FRAC)) u_rnd_dbl (
        .norm     (norm),
        .sign     (sign),
        .rnd_mode (rnd_mode),
        .frac_out (frac_d),
        .carry    (carry_d),
        .lost     (lost_d)
    );

    i2f_rounder #(.IN_W(OP_W), .FRAC_W(SGL_FRAC)) u_rnd_sgl (
        .norm     (norm),
        .sign     (sign),
        .rnd_mode (rnd_mode),
        .frac_out (frac_s),
        .carry    (carry_s),
        .lost     (lost_s)
    );

    // Pick the precision and pack sign, rebiased exponent and fraction.
    always_comb begin
        single     = prec_mode[1];
        is_zero    = (mag == '0);
        exact_path = ~int_kind[1] & ~single;
        if (single) begin
            frac_sel  = {frac_s, {PAD_W{1'b0}}};
            carry_sel = carry_s;
            lost_sel  = lost_s;
        end else begin
            frac_sel  = frac_d;
            carry_sel = carry_d;
            lost_sel  = lost_d;
        end
        exp_field = EXP_W'(EXP_BIAS + OP_W - 1) - EXP_W'(lz) + EXP_W'(carry_sel);
        if (is_zero) begin
            value_c = '0;
        end else begin
            value_c = {sign, exp_field, frac_sel};
        end
    end

    // Class code of the rounded value: only zero and normal numbers arise.
    always_comb begin
        if (is_zero) begin
            class_c = CLS_POS_ZERO;
        end else if (sign) begin
            class_c = CLS_NEG_NORM;
        end else begin
            class_c = CLS_POS_NORM;
        end
    end

    // Output register: value and class hold between conversions, strobes pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            inexact     <= 1'b0;
            fp_class    <= '0;
            flag_update <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            flag_update <= in_valid & ~exact_path;
            inexact     <= in_valid & ~exact_path & ~is_zero & lost_sel;
            if (in_valid) begin
                result   <= value_c;
                fp_class <= class_c;
            end
        end
    end
endmodule

// File: rtl/i2f_convert_chk.sv
// Temporal checks on the converter ports, attached by bind below.
// Assumes the synchronous active-low reset of the design.
module i2f_convert_chk
    import i2f_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  operand,
    input logic [1:0]       int_kind,
    input logic [1:0]       prec_mode,
    input logic             out_valid,
    input logic [OP_W-1:0]  result,
    input logic             inexact,
    input logic [CLS_W-1:0] fp_class,
    input logic             flag_update
);
    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    exact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !int_kind[1] && !prec_mode[1]) |=> (!flag_update && !inexact));

    // R6
    update_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int_kind[1] || prec_mode[1])) |=> flag_update);

    // R6
    inexact_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inexact |-> flag_update);

    // R4
    single_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prec_mode[1]) |=> (result[28:0] == 29'd0));

    // R9
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand == '0) |=> (result == '0 && !inexact && fp_class == CLS_POS_ZERO));

    // R2
    unsigned_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int_kind[0]) |=> !result[OP_W-1]);

    // R8
    class_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(fp_class[3:1]) == 1));
endmodule

bind i2f_convert i2f_convert_chk u_i2f_convert_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .operand     (operand),
    .int_kind    (int_kind),
    .prec_mode   (prec_mode),
    .out_valid   (out_valid),
    .result      (result),
    .inexact     (inexact),
    .fp_class    (fp_class),
    .flag_update (flag_update)
);

// File: tb/test_i2f_convert.sv
// Bench for i2f_convert: behavioural integer-arithmetic reference model,
// outputs compared on every falling edge against the previous cycle's drive.
module test_i2f_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  int_kind = '0;
    logic [1:0]  prec_mode = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        inexact;
    logic [4:0]  fp_class;
    logic        flag_update;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic        e_valid = 1'b0;
    logic [63:0] e_res = '0;
    logic        e_inx = 1'b0;
    logic        e_upd = 1'b0;
    logic [4:0]  e_cls = '0;
    logic        e_single = 1'b0;
    string       e_tag = "";

    i2f_convert i_i2f_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .int_kind(int_kind), .prec_mode(prec_mode), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .result(result), .inexact(inexact),
        .fp_class(fp_class), .flag_update(flag_update)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: sign/magnitude, top bit, drop excess bits, compare with one half.
    task automatic ref_conv(input logic [63:0] op, input logic [1:0] kind,
                            input logic [1:0] md, input logic [1:0] rm,
                            output logic [63:0] res, output logic inx,
                            output logic upd, output logic [4:0] cls);
        logic [63:0] mag, sig, rem, half, frac;
        logic neg, up, lost;
        int p, prec, d;
        neg = 1'b0;
        case (kind)
            2'd0: begin
                neg = op[31];
                mag = neg ? (64'h1_0000_0000 - {32'd0, op[31:0]}) : {32'd0, op[31:0]};
            end
            2'd1: mag = {32'd0, op[31:0]};
            2'd2: begin
                neg = op[63];
                mag = neg ? (~op + 64'd1) : op;
            end
            default: mag = op;
        endcase
        prec = md[1] ? 24 : 53;
        upd  = kind[1] | md[1];
        if (mag == 64'd0) begin
            res = 64'd0; inx = 1'b0; cls = 5'h12;
            return;
        end
        p = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) p = i;
        lost = 1'b0;
        if (p + 1 <= prec) begin
            sig = mag << (prec - 1 - p);
        end else begin
            d    = p + 1 - prec;
            sig  = mag >> d;
            rem  = mag & ((64'd1 << d) - 64'd1);
            half = 64'd1 << (d - 1);
            lost = (rem != 64'd0);
            case (rm)
                2'd0: up = (rem > half) || (rem == half && sig[0]);
                2'd1: up = 1'b0;
                2'd2: up = !neg && lost;
                default: up = neg && lost;
            endcase
            sig = sig + {63'd0, up};
            if (sig == (64'd1 << prec)) begin
                sig = sig >> 1;
                p = p + 1;
            end
        end
        frac = (sig & ((64'd1 << (prec - 1)) - 64'd1)) << (53 - prec);
        res  = {neg, 11'(p + 1023), frac[51:0]};
        inx  = lost & upd;
        cls  = neg ? 5'h08 : 5'h04;
    endtask

    // Compare outputs against the pending expectation (sampled on the falling edge).
    task automatic check_pending();
        chk("R3", {63'd0, out_valid}, {63'd0, e_valid});
        if (e_valid) begin
            chk(e_tag != "" ? e_tag : (e_single ? "R4" : "R2"), result, e_res);
            chk(e_upd ? "R6" : "R5", {63'd0, inexact}, {63'd0, e_inx});
            chk(e_upd ? "R6" : "R5", {63'd0, flag_update}, {63'd0, e_upd});
            chk("R8", {59'd0, fp_class}, {59'd0, e_cls});
        end else begin
            chk("R3", {62'd0, inexact, flag_update}, 64'd0);
        end
    endtask

    // Check the previous drive, then present one operand for one cycle.
    task automatic drive(input logic [63:0] op, input logic [1:0] kind,
                         input logic [1:0] md, input logic [1:0] rm, input string tag);
        logic [63:0] r; logic x, u; logic [4:0] c;
        @(negedge clk);
        check_pending();
        ref_conv(op, kind, md, rm, r, x, u, c);
        in_valid = 1'b1; operand = op; int_kind = kind; prec_mode = md; rnd_mode = rm;
        e_valid = 1'b1; e_res = r; e_inx = x; e_upd = u; e_cls = c;
        e_single = md[1]; e_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
        e_valid = 1'b0; e_tag = "";
    endtask

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any conversion
        chk("R1", {out_valid, inexact, flag_update, fp_class}, 8'd0);
        chk("R1", result, 64'd0);

        drive(64'd0, 2'd3, 2'd0, 2'd0, "R9");
        drive(64'hFFFF_FFFF_0000_0000, 2'd0, 2'd0, 2'd0, "R9");
        drive(64'h1234_5678_8000_0000, 2'd0, 2'd0, 2'd0, "R10");
        drive(64'h8000_0000_0000_0000, 2'd2, 2'd0, 2'd0, "R10");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd0, 2'd0, "R12");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd0, 2'd1, "R7");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 2'd0, 2'd0, "R2");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd0, 2'd0, "R2");
        drive(64'h0000_0000_0100_0001, 2'd2, 2'd2, 2'd0, "R7");
        drive(64'h0000_0000_0100_0001, 2'd2, 2'd2, 2'd2, "R7");
        drive(64'hFFFF_FFFF_FEFF_FFFF, 2'd2, 2'd2, 2'd3, "R7");
        drive(64'h0000_0000_0100_0003, 2'd1, 2'd2, 2'd0, "R4");
        drive(64'h0020_0000_0000_0001, 2'd3, 2'd0, 2'd0, "R7");
        drive(64'h0020_0000_0000_0003, 2'd3, 2'd0, 2'd0, "R7");
        idle();
        // R11: record bit toggled, outputs identical
        drive(64'h0123_4567_89AB_CDEF, 2'd2, 2'd3, 2'd2, "R11");
        drive(64'h0123_4567_89AB_CDEF, 2'd2, 2'd2, 2'd2, "R11");
        drive(64'h0000_0000_8765_4321, 2'd0, 2'd1, 2'd0, "R11");
        drive(64'h0000_0000_8765_4321, 2'd0, 2'd0, 2'd0, "R11");
        idle();
        for (int k = 0; k < 3000; k++) begin
            rv = {$urandom, $urandom};
            rv = rv >> ($urandom % 64);
            if (($urandom % 4) == 0) rv = ~rv;
            drive(rv, 2'($urandom), 2'($urandom), 2'($urandom), "");
            if (($urandom % 8) == 0) idle();
        end
        idle();
        idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule